// File: doc/BRIEF.md
# Compare-Triggered Sync Pulse Generator

This block watches a free-running 64-bit time value supplied from outside and compares it, every cycle, with a bank of programmable 64-bit compare values. Each compare channel has its own enable and a sticky match flag that software clears by writing a one to it. Compare 0 marks the end of a cycle. When compare 0 matches, the block can ask the external counter to restart from zero. An optional shadow mode holds newly written compare values back until that cycle wrap.

A match on compare 1 starts the sync engine. After an optional start delay, the engine drives the sync output high for a programmed number of clock cycles. With a zero period it fires once per match. With a nonzero period it keeps re-firing at that spacing until software turns it off. A two-bit control word gates the engine. One bit is a global enable and the other enables this output. Clearing either bit drops the output at once and abandons any pending pulse.

Top module: `sync_cmp_pulse_gen`

## Requirements
- R1: After reset `sync0_out`, `cnt_clear` and every `cmp_status` bit are 0. All compares are disabled, so a time value equal to a compare's reset value of 0 sets no status bit.
- R2: Compare n is written as its low 32-bit half at word address 8+2n and its high half at 9+2n. It is enabled by bit n+1 of the compare config word at address 0. While compare n is enabled and `time_in` equals its full 64-bit value, `cmp_status[n]` is 1 from the next cycle on.
- R3: The status word at address 1 is write-1-to-clear. Written zero bits leave their flags alone. A match in the same cycle as a clearing write leaves the flag set.
- R4: `cnt_clear` is high in the very cycle that compare 0 matches, and only when bit 0 of the compare config word is 1.
- R5: While the shadow bit is 0, a written compare half is used for matching from the following cycle. The shadow bit is bit 17 of the config word (bit NUM_CMP+1).
- R6: While the shadow bit is 1, written compare values are held back. The values in force are replaced by the written ones only in a cycle where compare 0 matches.
- R7: The control word at address 2 holds the global enable in bit 0 and the output enable in bit 1. The pulse width is at address 3 and the period at address 4. With both enables set, period 0 and delay 0, a compare-1 match makes `sync0_out` high for exactly width cycles, starting the cycle after the match, once.
- R8: A width of 0 gives a pulse of one cycle.
- R9: With a nonzero period P, the pulse rises again every P cycles after the first rise until the generator is disabled.
- R10: A start delay D at address 5 shifts the first rise D cycles later than with delay 0. The width is unchanged.
- R11: A write that clears either control bit drives `sync0_out` low from the next cycle and cancels the pulse train. Re-enabling does not resume the pulse without a new compare-1 match.
- R12: A compare-1 match while either control bit is 0 sets its status bit but produces no pulse.
- R13: A compare-1 match while a pulse is pending or running is ignored by the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_in | input | 64 | Current time counter value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register word address |
| wr_data | input | 32 | Register write data |
| cmp_status | output | 16 | Sticky per-compare match flags |
| cnt_clear | output | 1 | Request to restart the time counter on a compare-0 match |
| sync0_out | output | 1 | Sync pulse output |

## Verification
The bench targets off-by-one errors in the pulse engine. A zero width, a start delay and the re-fire spacing of a periodic train are each measured to the exact cycle. A counter that reloads one cycle early or late would show up as a wrong pulse count or a wrong gap. The bench also hits the status flag with a match and a clearing write in the same cycle. A design that let the clear win would lose that event. Both shadow settings are exercised: a design that applied the written value immediately in shadow mode would match the new value before the compare-0 wrap. Finally, the generator is disabled in the middle of a pulse and then re-enabled. A design that only masked the output, without resetting the engine, would resume the old pulse train.

// File: rtl/sync_cmp_pkg.sv
package sync_cmp_pkg;

    // Register word addresses
    localparam int unsigned ADR_CMP_CFG   = 0;
    localparam int unsigned ADR_CMP_STAT  = 1;
    localparam int unsigned ADR_SYNC_CTRL = 2;
    localparam int unsigned ADR_PWIDTH    = 3;
    localparam int unsigned ADR_PERIOD    = 4;
    localparam int unsigned ADR_DELAY     = 5;
    localparam int unsigned ADR_CMP_BASE  = 8;   // compare n: low at base+2n, high at base+2n+1

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WAIT = 2'd1,
        ENG_RUN  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/sync_cmp_regs.sv
module sync_cmp_regs
    import sync_cmp_pkg::*;
#(
    parameter int NUM_CMP = 16,
    parameter int REG_W   = 32,
    parameter int ADDR_W  = 6,
    localparam int CNT_W  = 2 * REG_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    input  logic [NUM_CMP-1:0]              match,
    output logic [NUM_CMP-1:0]              cmp_en,
    output logic                            rst_on_cmp0,
    output logic                            run_en,
    output logic [REG_W-1:0]                pulse_width,
    output logic [REG_W-1:0]                period,
    output logic [REG_W-1:0]                start_delay,
    output logic [NUM_CMP-1:0][CNT_W-1:0]   active_cmp,
    output logic [NUM_CMP-1:0]              status
);

    localparam int SHADOW_BIT = NUM_CMP + 1;
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(ADR_CMP_CFG);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_CMP_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_SYNC_CTRL);
    localparam logic [ADDR_W-1:0] A_WIDTH = ADDR_W'(ADR_PWIDTH);
    localparam logic [ADDR_W-1:0] A_PER   = ADDR_W'(ADR_PERIOD);
    localparam logic [ADDR_W-1:0] A_DLY   = ADDR_W'(ADR_DELAY);

    typedef struct packed {
        logic                          rst0;
        logic [NUM_CMP-1:0]            en;
        logic                          shadow;
        logic                          glb;
        logic                          out_en;
        logic [REG_W-1:0]              width;
        logic [REG_W-1:0]              per;
        logic [REG_W-1:0]              dly;
        logic [NUM_CMP-1:0]            status;
        logic [NUM_CMP-1:0][CNT_W-1:0] pend;
        logic [NUM_CMP-1:0][CNT_W-1:0] live;
    } regs_t;

    regs_t q, d;
    logic [NUM_CMP-1:0] clr_mask;
    logic               wrap;
    logic               unused_hi_bits;

    assign unused_hi_bits = ^wr_data[REG_W-1:SHADOW_BIT+1];
    assign wrap = match[0];

    always_comb begin
        d = q;
        clr_mask = '0;
        if (wr_en) begin
            if (wr_addr == A_CFG) begin
                d.rst0   = wr_data[0];
                d.en     = wr_data[NUM_CMP:1];
                d.shadow = wr_data[SHADOW_BIT];
            end
            if (wr_addr == A_STAT) begin
                clr_mask = wr_data[NUM_CMP-1:0];
            end
            if (wr_addr == A_CTRL) begin
                d.glb    = wr_data[0];
                d.out_en = wr_data[1];
            end
            if (wr_addr == A_WIDTH) begin
                d.width = wr_data;
            end
            if (wr_addr == A_PER) begin
                d.per = wr_data;
            end
            if (wr_addr == A_DLY) begin
                d.dly = wr_data;
            end
            for (int n = 0; n < NUM_CMP; n++) begin
                if (wr_addr == ADDR_W'(ADR_CMP_BASE + 2 * n)) begin
                    d.pend[n][REG_W-1:0] = wr_data;
                end
                if (wr_addr == ADDR_W'(ADR_CMP_BASE + 2 * n + 1)) begin
                    d.pend[n][CNT_W-1:REG_W] = wr_data;
                end
            end
        end
        // a new match wins over a clearing write
        d.status = (q.status & ~clr_mask) | match;
        // the values in force follow the written ones unless held for the wrap
        for (int n = 0; n < NUM_CMP; n++) begin
            if (!q.shadow || wrap) begin
                d.live[n] = d.pend[n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmp_en      = q.en;
    assign rst_on_cmp0 = q.rst0;
    assign run_en      = q.glb & q.out_en;
    assign pulse_width = q.width;
    assign period      = q.per;
    assign start_delay = q.dly;
    assign active_cmp  = q.live;
    assign status      = q.status;

endmodule

// File: rtl/sync_cmp_match.sv
module sync_cmp_match #(
    parameter int NUM_CMP = 16,
    parameter int CNT_W   = 64
) (
    input  logic [CNT_W-1:0]              time_in,
    input  logic [NUM_CMP-1:0]            cmp_en,
    input  logic                          rst_on_cmp0,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] active_cmp,
    output logic [NUM_CMP-1:0]            match,
    output logic                          cnt_clear
);

    for (genvar n = 0; n < NUM_CMP; n++) begin : g_cmp
        assign match[n] = cmp_en[n] && (time_in == active_cmp[n]);
    end

    assign cnt_clear = match[0] && rst_on_cmp0;

endmodule

// File: rtl/sync_pulse_engine.sv
module sync_pulse_engine
    import sync_cmp_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             run_en,
    input  logic [REG_W-1:0] pulse_width,
    input  logic [REG_W-1:0] period,
    input  logic [REG_W-1:0] start_delay,
    output logic             sync_out,
    output logic             busy
);

    localparam logic [REG_W-1:0] ONE = REG_W'(1);

    typedef struct packed {
        eng_state_e       state;
        logic [REG_W-1:0] hi_cnt;
        logic [REG_W-1:0] per_cnt;
        logic [REG_W-1:0] dly_cnt;
    } eng_t;

    eng_t q, d;
    logic [REG_W-1:0] width_eff;

    assign width_eff = (pulse_width == '0) ? ONE : pulse_width;

    always_comb begin
        d = q;
        if (!run_en) begin
            d.state   = ENG_IDLE;
            d.hi_cnt  = '0;
            d.per_cnt = '0;
            d.dly_cnt = '0;
        end else begin
            case (q.state)
                ENG_IDLE: begin
                    if (trig) begin
                        if (start_delay == '0) begin
                            d.state   = ENG_RUN;
                            d.hi_cnt  = width_eff;
                            d.per_cnt = period;
                        end else begin
                            d.state   = ENG_WAIT;
                            d.dly_cnt = start_delay;
                        end
                    end
                end
                ENG_WAIT: begin
                    d.dly_cnt = q.dly_cnt - ONE;
                    if (q.dly_cnt <= ONE) begin
                        d.state   = ENG_RUN;
                        d.hi_cnt  = width_eff;
                        d.per_cnt = period;
                    end
                end
                ENG_RUN: begin
                    if (q.hi_cnt != '0) begin
                        d.hi_cnt = q.hi_cnt - ONE;
                    end
                    if (period == '0) begin
                        if (q.hi_cnt <= ONE) begin
                            d.state = ENG_IDLE;
                        end
                    end else begin
                        d.per_cnt = q.per_cnt - ONE;
                        if (q.per_cnt <= ONE) begin
                            d.hi_cnt  = width_eff;
                            d.per_cnt = period;
                        end
                    end
                end
                default: begin
                    d.state = ENG_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sync_out = run_en && (q.hi_cnt != '0);
    assign busy     = (q.state != ENG_IDLE);

endmodule

// File: rtl/sync_cmp_pulse_gen.sv
module sync_cmp_pulse_gen #(
    parameter int NUM_CMP = 16,
    parameter int REG_W   = 32,
    parameter int ADDR_W  = 6,
    localparam int CNT_W  = 2 * REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   time_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic [NUM_CMP-1:0] cmp_status,
    output logic               cnt_clear,
    output logic               sync0_out
);

    logic [NUM_CMP-1:0]            match_w;
    logic [NUM_CMP-1:0]            cmp_en_w;
    logic                          rst0_w;
    logic                          run_en_w;
    logic                          busy_w;
    logic [REG_W-1:0]              width_w;
    logic [REG_W-1:0]              period_w;
    logic [REG_W-1:0]              delay_w;
    logic [NUM_CMP-1:0][CNT_W-1:0] active_w;

    sync_cmp_regs #(
        .NUM_CMP (NUM_CMP),
        .REG_W   (REG_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .match       (match_w),
        .cmp_en      (cmp_en_w),
        .rst_on_cmp0 (rst0_w),
        .run_en      (run_en_w),
        .pulse_width (width_w),
        .period      (period_w),
        .start_delay (delay_w),
        .active_cmp  (active_w),
        .status      (cmp_status)
    );

    sync_cmp_match #(
        .NUM_CMP (NUM_CMP),
        .CNT_W   (CNT_W)
    ) u_match (
        .time_in     (time_in),
        .cmp_en      (cmp_en_w),
        .rst_on_cmp0 (rst0_w),
        .active_cmp  (active_w),
        .match       (match_w),
        .cnt_clear   (cnt_clear)
    );

    sync_pulse_engine #(
        .REG_W (REG_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (match_w[1]),
        .run_en      (run_en_w),
        .pulse_width (width_w),
        .period      (period_w),
        .start_delay (delay_w),
        .sync_out    (sync0_out),
        .busy        (busy_w)
    );

endmodule

// File: rtl/sync_cmp_checker.sv
module sync_cmp_checker
    import sync_cmp_pkg::*;
#(
    parameter int NUM_CMP = 16,
    parameter int ADDR_W  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NUM_CMP-1:0] wr_clr,
    input logic [NUM_CMP-1:0] match,
    input logic [NUM_CMP-1:0] status,
    input logic               cnt_clear,
    input logic               run_en,
    input logic               busy,
    input logic               sync_out
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_CMP_STAT);

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
        // R2: a match leaves its flag set on the next cycle
        assert_status_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            match[i] |=> status[i]);
        // R3: a flag only drops after a write of 1 to its status bit
        assert_w1c_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status[i]) |-> $past(wr_en && (wr_addr == A_STAT) && wr_clr[i]));
    end

    // R4: the counter restart request needs a compare-0 match
    assert_clear_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |-> match[0]);

    // R11: a disabled generator is idle from the next cycle
    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !busy);

    // R12: no output the cycle after the generator is off
    assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !sync_out);

    // R7: a rising output follows a compare-1 match or a running train
    assert_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(match[1] || busy));

endmodule

bind sync_cmp_pulse_gen sync_cmp_checker #(
    .NUM_CMP (NUM_CMP),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_clr    (wr_data[NUM_CMP-1:0]),
    .match     (match_w),
    .status    (cmp_status),
    .cnt_clear (cnt_clear),
    .run_en    (run_en_w),
    .busy      (busy_w),
    .sync_out  (sync0_out)
);

// File: tb/sync_cmp_pulse_gen_test.sv
module sync_cmp_pulse_gen_test;

    localparam logic [63:0] IDLE_T = 64'hFFFF_0000_0000_0000;
    localparam logic [5:0] A_CFG = 6'd0, A_STAT = 6'd1, A_CTRL = 6'd2;
    localparam logic [5:0] A_WID = 6'd3, A_PER = 6'd4, A_DLY = 6'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_in = IDLE_T;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] cmp_status;
    logic        cnt_clear;
    logic        sync0_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sync_cmp_pulse_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_in    (time_in),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmp_status (cmp_status),
        .cnt_clear  (cnt_clear),
        .sync0_out  (sync0_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmp_write(input int n, input logic [63:0] v);
        wr(6'(8 + 2 * n), v[31:0]);
        wr(6'(9 + 2 * n), v[63:32]);
    endtask

    task automatic hit(input logic [63:0] t);
        @(negedge clk);
        time_in = t;
        @(negedge clk);
        time_in = IDLE_T;
    endtask

    // drives a match at t, then observes ncyc cycles; re-drives t at cycle retrig
    task automatic run_pulse(input logic [63:0] t, input int ncyc, input int retrig,
                             output int first, output int cnt, output int nrise, output int gap);
        int r0;
        logic prev;
        first = 0; cnt = 0; nrise = 0; gap = 0; r0 = 0; prev = 1'b0;
        @(negedge clk);
        time_in = t;
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            time_in = (k == retrig) ? t : IDLE_T;
            if (sync0_out) begin
                cnt++;
                if (first == 0) first = k;
                if (!prev) begin
                    nrise++;
                    if (nrise == 1) r0 = k;
                    if (nrise == 2) gap = k - r0;
                end
            end
            prev = sync0_out;
        end
        time_in = IDLE_T;
    endtask

    task automatic t_reset;
        check("R1 sync0_out", sync0_out, 0);
        check("R1 status", cmp_status, 0);
        check("R1 cnt_clear", cnt_clear, 0);
        hit(64'd0);
        check("R1 disabled compares", cmp_status, 0);
    endtask

    task automatic t_oneshot;
        int f, c, nr, g;
        cmp_write(1, 64'd100);
        wr(A_CFG, 32'h4);
        wr(A_WID, 32'd3);
        wr(A_PER, 32'd0);
        wr(A_DLY, 32'd0);
        wr(A_CTRL, 32'd3);
        run_pulse(64'd100, 12, 0, f, c, nr, g);
        check("R7 first high cycle", f, 1);
        check("R7 high count", c, 3);
        check("R7 single pulse", nr, 1);
        check("R2 status bit 1", cmp_status[1], 1);
    endtask

    task automatic t_w1c;
        wr(A_STAT, 32'h0);
        check("R3 zero write keeps flag", cmp_status[1], 1);
        @(negedge clk);
        time_in = 64'd100;
        wr_en = 1'b1; wr_addr = A_STAT; wr_data = 32'h2;
        @(negedge clk);
        wr_en = 1'b0; time_in = IDLE_T;
        check("R3 set wins over clear", cmp_status[1], 1);
        repeat (6) @(negedge clk);
        wr(A_STAT, 32'h2);
        check("R3 write 1 clears", cmp_status[1], 0);
    endtask

    task automatic t_wide;
        cmp_write(2, {32'd1, 32'd5});
        wr(A_CFG, 32'hC);
        hit(64'd5);
        check("R2 low half alone no match", cmp_status[2], 0);
        hit({32'd1, 32'd5});
        check("R2 full 64-bit match", cmp_status[2], 1);
        wr(A_STAT, 32'hFFFF);
    endtask

    task automatic t_shadow_off;
        wr(6'd10, 32'd300);
        time_in = 64'd300;
        @(negedge clk);
        time_in = IDLE_T;
        check("R5 new value used next cycle", cmp_status[1], 1);
        wr(A_STAT, 32'hFFFF);
        hit(64'd100);
        check("R5 old value replaced", cmp_status[1], 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_cnt_clear;
        cmp_write(0, 64'd50);
        wr(A_CFG, 32'h7);
        @(negedge clk);
        time_in = 64'd50;
        #1;
        check("R4 clear in match cycle", cnt_clear, 1);
        @(negedge clk);
        time_in = IDLE_T;
        check("R4 compare 0 status", cmp_status[0], 1);
        wr(A_CFG, 32'h6);
        @(negedge clk);
        time_in = 64'd50;
        #1;
        check("R4 no clear without bit 0", cnt_clear, 0);
        @(negedge clk);
        time_in = IDLE_T;
        wr(A_STAT, 32'hFFFF);
    endtask

    task automatic t_shadow_on;
        wr(A_CFG, 32'h0002_0007);
        wr(6'd10, 32'd400);
        hit(64'd400);
        check("R6 held value not yet used", cmp_status[1], 0);
        hit(64'd300);
        check("R6 old value still in force", cmp_status[1], 1);
        repeat (5) @(negedge clk);
        wr(A_STAT, 32'hFFFF);
        hit(64'd50);
        hit(64'd400);
        check("R6 new value after wrap", cmp_status[1], 1);
        repeat (5) @(negedge clk);
        wr(A_CFG, 32'h4);
        cmp_write(1, 64'd100);
        wr(A_STAT, 32'hFFFF);
    endtask

    task automatic t_zero_width;
        int f, c, nr, g;
        wr(A_WID, 32'd0);
        run_pulse(64'd100, 8, 0, f, c, nr, g);
        check("R8 zero width first", f, 1);
        check("R8 zero width one cycle", c, 1);
    endtask

    task automatic t_periodic;
        int f, c, nr, g;
        wr(A_WID, 32'd2);
        wr(A_PER, 32'd6);
        run_pulse(64'd100, 20, 0, f, c, nr, g);
        check("R9 rise count", nr, 4);
        check("R9 spacing", g, 6);
        check("R9 high count", c, 8);
        wr(A_CTRL, 32'd1);
        c = 0;
        for (int k = 0; k < 10; k++) begin
            if (sync0_out) c++;
            @(negedge clk);
        end
        check("R11 output enable off stops train", c, 0);
        wr(A_PER, 32'd0);
        wr(A_CTRL, 32'd3);
    endtask

    task automatic t_delay;
        int f, c, nr, g;
        wr(A_DLY, 32'd4);
        run_pulse(64'd100, 12, 0, f, c, nr, g);
        check("R10 delayed first high", f, 5);
        check("R10 width unchanged", c, 2);
        wr(A_DLY, 32'd0);
    endtask

    task automatic t_disable_mid;
        int c;
        wr(A_WID, 32'd10);
        @(negedge clk);
        time_in = 64'd100;
        @(negedge clk);
        time_in = IDLE_T;
        check("R11 pulse started", sync0_out, 1);
        @(negedge clk);
        wr(A_CTRL, 32'd0);
        check("R11 low after disable", sync0_out, 0);
        wr(A_CTRL, 32'd3);
        c = 0;
        for (int k = 0; k < 12; k++) begin
            if (sync0_out) c++;
            @(negedge clk);
        end
        check("R11 no resume after re-enable", c, 0);
    endtask

    task automatic t_off_ignore;
        int f, c, nr, g;
        wr(A_STAT, 32'hFFFF);
        wr(A_CTRL, 32'd2);
        run_pulse(64'd100, 8, 0, f, c, nr, g);
        check("R12 no pulse while off", c, 0);
        check("R12 status still set", cmp_status[1], 1);
        wr(A_CTRL, 32'd3);
    endtask

    task automatic t_busy;
        int f, c, nr, g;
        wr(A_WID, 32'd8);
        run_pulse(64'd100, 14, 3, f, c, nr, g);
        check("R13 single rise", nr, 1);
        check("R13 width not extended", c, 8);
    endtask

    initial begin : wd
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_w1c();
        t_wide();
        t_shadow_off();
        t_cnt_clear();
        t_shadow_on();
        t_zero_width();
        t_periodic();
        t_delay();
        t_disable_mid();
        t_off_ignore();
        t_busy();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule